// File: doc/BRIEF.md
# Latched Bidirectional Wired-OR Transceiver

This block is a cycle-level model of an 8-bit transceiver between a local logic port (A) and a wired-OR backplane port (B). Each port is represented by separate input, output and enable signals rather than tristate nets. On the A side, the outputs are three-state: an enable flag qualifies the data. On the B side, each bit has an open-drain style pull-down request. A bit either pulls the shared line low or releases it, and the resolved line level comes back on `bLine`.

A single shared storage element sits in the data path. When `latchEn` is low, the storage is transparent: the outputs follow the selected source combinationally, and the value is sampled on every rising clock edge. When `latchEn` is high, the storage holds what it last sampled. The source of the storage depends on the A enable:

- With A outputs off, the source is port A, so data moves from A to B.
- With A outputs on, the source is the backplane line, so data moves from B to A.

The two B enables must both be low before any B bit may pull. When both ports drive and the storage holds, the stored word goes out on both sides. When both ports drive and the storage is transparent, a combinational loop through the backplane exists, and `loopFlag` reports it. By default the B side has the opposite polarity to the A side. A parameter selects the non-inverting variant.

Top module: `xcvr_latched`

## Requirements
- R1: `aOe` is 1 exactly when `oeA` is 1.
- R2: If `oeB0` or `oeB1` is 1, every bit of `bPullDn` is 0.
- R3: While `latchEn` is 0, the storage is transparent: `aOut` equals the selected source in the same cycle.
- R4: While `latchEn` is 1, `aOut` equals the source value sampled at the last rising clock edge at which `latchEn` was 0. Reset clears the stored value to zero.
- R5: The source is `aIn` when `oeA` is 0. When `oeA` is 1, the source is the backplane line converted to A polarity.
- R6: With INVERT=1 (default), an enabled B bit pulls down when the latch bit is 1, and the A-polarity value of a line bit is its complement. With INVERT=0, an enabled bit pulls down when the latch bit is 0, and the line bit is taken as is.
- R7: When `latchEn`=1, `oeA`=1 and both B enables are 0, the stored word is driven to A and to B at the same time.
- R8: `loopFlag` is 1 exactly when `latchEn`=0, `oeA`=1 and both B enables are 0.
- R9: `aOut` always presents the current latch value, whatever the state of `aOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the storage element |
| rst | input | 1 | Synchronous reset, active high, clears storage |
| latchEn | input | 1 | 0 = transparent, 1 = hold |
| oeA | input | 1 | A output enable, active high |
| oeB0 | input | 1 | First B enable, active low |
| oeB1 | input | 1 | Second B enable, active low |
| aIn | input | 8 | Level seen on port A |
| aOut | output | 8 | Data presented to port A |
| aOe | output | 1 | Port A drivers active |
| bLine | input | 8 | Resolved wired-OR backplane level |
| bPullDn | output | 8 | Per-bit pull-down request onto the backplane |
| loopFlag | output | 1 | Transparent feedback path through both ports |

## Verification
The hardest situation to reach is a hold that starts from the B side. To set it up, the storage must first be transparent with A enabled, so that it samples the backplane. It must then hold across a change of the line. Only after that can both ports be switched on, so that the captured word appears on both sides.

A fixed-seed random run draws all sixteen combinations of latch enable and the three output enables. Each cycle also gets fresh A and line words. This produces long runs of mixed hold and transparent cycles. A directed capture sequence checks the B-sourced hold and the dual drive. A second instance with the non-inverting variant faces the same stimulus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic hold;   // storage holds
    logic enA;    // A drivers on
    logic enB;    // B drivers may pull
    logic pickB;  // storage source is backplane
    logic loop;   // feedback path present
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic       latchEn,
  input  logic       oeA,
  input  logic       oeB0,
  input  logic       oeB1,
  output xcvr_ctl_t  ctl
);
  logic bothLow;
  assign bothLow = ~oeB0 & ~oeB1;

  always_comb begin
    ctl.hold  = latchEn;
    ctl.enA   = oeA;
    ctl.enB   = bothLow;
    ctl.pickB = oeA;
    ctl.loop  = ~latchEn & oeA & bothLow;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvr_ctl_t        ctl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bLine,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bPullDn
);
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] srcVal;
  logic [WIDTH-1:0] latchVal;
  logic [WIDTH-1:0] lineAsA;
  logic [WIDTH-1:0] pullPat;

  generate
    if (INVERT) begin : g_inv
      assign lineAsA = ~bLine;
      assign pullPat = latchVal;
    end else begin : g_noninv
      assign lineAsA = bLine;
      assign pullPat = ~latchVal;
    end
  endgenerate

  assign srcVal   = ctl.pickB ? lineAsA : aIn;
  assign latchVal = ctl.hold ? stored : srcVal;
  assign aOut     = latchVal;
  assign bPullDn  = ctl.enB ? pullPat : '0;

  always_ff @(posedge clk) begin
    if (rst)            stored <= '0;
    else if (!ctl.hold) stored <= srcVal;
  end

  // R4: held contents never move
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    ctl.hold && $past(ctl.hold) && !$past(rst) |-> $stable(stored));
  // R4: first held cycle keeps the last transparent sample
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    ctl.hold && !$past(ctl.hold) && !$past(rst) |-> stored == $past(srcVal));
endmodule

// File: rtl/xcvr_latched.sv
module xcvr_latched
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latchEn,
  input  logic             oeA,
  input  logic             oeB0,
  input  logic             oeB1,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bLine,
  output logic [WIDTH-1:0] bPullDn,
  output logic             loopFlag
);
  xcvr_ctl_t ctl;

  xcvr_ctrl u_ctrl (
    .latchEn(latchEn), .oeA(oeA), .oeB0(oeB0), .oeB1(oeB1), .ctl(ctl)
  );

  xcvr_datapath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .aIn(aIn), .bLine(bLine),
    .aOut(aOut), .bPullDn(bPullDn)
  );

  assign aOe      = ctl.enA;
  assign loopFlag = ctl.loop;

  // R2: any high B enable releases the whole backplane
  a_r2_b_release: assert property (@(posedge clk) disable iff (rst)
    (oeB0 || oeB1) |-> bPullDn == '0);
  // R8: feedback only exists while transparent
  a_r8_loop_transparent: assert property (@(posedge clk) disable iff (rst)
    loopFlag |-> !latchEn && aOe);
  // R7: held word goes to both ports with matching polarity
  a_r7_dual_drive: assert property (@(posedge clk) disable iff (rst)
    latchEn && aOe && !oeB0 && !oeB1 |->
      bPullDn == (INVERT ? aOut : ~aOut));
  // R7/R4: dual drive in hold keeps A data steady
  a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
    latchEn && $past(latchEn) && !$past(rst) |-> $stable(aOut));
endmodule

// File: tb/sim_xcvr_latched.sv
module sim_xcvr_latched;
  logic clk = 1'b0;
  logic rst;
  logic latchEn, oeA, oeB0, oeB1;
  logic [7:0] aIn, bLine;
  logic [7:0] aOut0, aOut1, pd0, pd1;
  logic aOe0, aOe1, loop0, loop1;
  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] st0, st1;

  always #10 clk = ~clk;

  xcvr_latched #(.WIDTH(8), .INVERT(1'b1)) u0 (
    .clk(clk), .rst(rst), .latchEn(latchEn), .oeA(oeA), .oeB0(oeB0), .oeB1(oeB1),
    .aIn(aIn), .aOut(aOut0), .aOe(aOe0), .bLine(bLine), .bPullDn(pd0), .loopFlag(loop0));
  xcvr_latched #(.WIDTH(8), .INVERT(1'b0)) u1 (
    .clk(clk), .rst(rst), .latchEn(latchEn), .oeA(oeA), .oeB0(oeB0), .oeB1(oeB1),
    .aIn(aIn), .aOut(aOut1), .aOe(aOe1), .bLine(bLine), .bPullDn(pd1), .loopFlag(loop1));

  function automatic logic [7:0] srcOf(bit inv);
    if (oeA) return inv ? ~bLine : bLine;
    return aIn;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [7:0] v0, v1;
    bit enB;
    enB = !oeB0 && !oeB1;
    v0 = latchEn ? st0 : srcOf(1'b1);          // R3 R4 R5
    v1 = latchEn ? st1 : srcOf(1'b0);
    chk("R1 aOe", {7'b0, aOe0}, {7'b0, oeA});
    chk("R9 aOut inv", aOut0, v0);
    chk("R9 aOut noninv", aOut1, v1);
    chk("R2/R6 pull inv", pd0, enB ? v0 : 8'h00);
    chk("R2/R6 pull noninv", pd1, enB ? ~v1 : 8'h00);
    chk("R8 loop", {7'b0, loop0}, {7'b0, (!latchEn && oeA && enB)});
  endtask

  task automatic step(logic le, logic oa, logic b0, logic b1, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    latchEn = le; oeA = oa; oeB0 = b0; oeB1 = b1; aIn = a; bLine = b;
    #2 checkAll();
    @(posedge clk);
    if (!rst && !latchEn) begin
      st0 = srcOf(1'b1);
      st1 = srcOf(1'b0);
    end
  endtask

  initial begin
    #3000000;
    nFails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; latchEn = 1'b1; oeA = 1'b0; oeB0 = 1'b1; oeB1 = 1'b1;
    aIn = 8'hA5; bLine = 8'h3C;
    st0 = 8'h00; st1 = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 reset value", aOut0, 8'h00);
    chk("R4 reset value noninv", aOut1, 8'h00);
    rst = 1'b0;
    // R5/R3: sample A, then hold and drive B
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'hFF);
    chk("R4 held A sample", aOut0, 8'h96);
    // R5/R7: sample B line, hold across line change, then dual drive
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h0F);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hAA);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 8'h77);
    chk("R7 dual drive A", aOut0, 8'hF0);
    chk("R7 dual drive B", pd0, 8'hF0);
    chk("R6 noninv dual B", pd1, ~8'h0F);
    // R8: feedback
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hC3);
    // full sweep of control combinations
    for (int c = 0; c < 16; c++)
      step(c[3], c[2], c[1], c[0], 8'($urandom), 8'($urandom));
    // random mix with sticky hold runs
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      step(c[3] | (($urandom % 3) == 0), c[2], c[1], c[0], 8'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule